// File: doc/BRIEF.md
# BCD Seven-Segment Latch Decoder

This block holds one 8-4-2-1 weighted decimal digit and turns it into the seven drive levels for a numeric display. Segment bits are ordered a through g, from bit 0 to bit 6. A track control chooses between two behaviours. While it is high, the digit input flows through to the decoder. While it is low, the last captured digit is held.

A blank control forces every segment off. A phase control flips the polarity of all seven outputs. This lets the same block drive common-cathode LEDs (phase low), common-anode LEDs (phase high) or a liquid-crystal panel.

In LCD mode an internal divider produces a square-wave backplane. The block uses that same wave as its own phase, so the segment levels and the backplane stay aligned on every cycle. Codes 10 to 15 show nothing. Digits 6 and 9 are drawn with their tails.

Top module: `bcd_seg_latch`

## Requirements
- R1: While rst_ni is low, seg_o and backplane_o read 0 and the stored digit is cleared to 0. The first clock edge after reset, with track_i, blank_i, invert_i and lcd_mode_i all low, yields seg_o = 7'h3F.
- R2: On a clock edge with track_i high, the digit stored is digit_i, and seg_o after that edge shows that digit.
- R3: On a clock edge with track_i low, the stored digit keeps its value whatever digit_i does.
- R4: With the phase low and blank_i low, seg_o (bit0=a … bit6=g) decodes digits 0 to 9 as follows:
  - 0 → 3F
  - 1 → 06
  - 2 → 5B
  - 3 → 4F
  - 4 → 66
  - 5 → 6D
  - 6 → 7D (top bar lit)
  - 7 → 07 (a, b, c only)
  - 8 → 7F
  - 9 → 6F (bottom bar lit)
- R5: Codes 10 to 15 give an all-off pattern, 7'h00, before phase inversion.
- R6: blank_i high gives an all-off pattern before phase inversion, whatever track_i and digit_i are.
- R7: Blanking does not stop capture. After blank_i falls, seg_o shows the digit that was stored while blanked.
- R8: In LED mode (lcd_mode_i low) with invert_i high, seg_o is the bitwise inverse of the phase-low result. This includes the blank and invalid-code patterns.
- R9: In LCD mode, backplane_o toggles every DIV_CLKS clocks, and seg_o uses backplane_o of the same cycle as its phase.
- R10: In LED mode, backplane_o is held at 0 and the phase is taken from invert_i.
- R11: Every output is registered. An input change shows on seg_o exactly one clock edge later, and never before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| digit_i | input | 4 | BCD digit in |
| track_i | input | 1 | 1: load digit_i each clock; 0: hold the stored digit |
| blank_i | input | 1 | Forces all segments off |
| invert_i | input | 1 | Output phase in LED mode |
| lcd_mode_i | input | 1 | 1: phase comes from the internal backplane divider |
| seg_o | output | 7 | Segment levels, bit0 = a … bit6 = g |
| backplane_o | output | 1 | LCD backplane square wave; 0 in LED mode |

## Verification
The assertions assume that every input is a steady, known level at each rising clock edge. They also assume that reset is held for at least one edge, so that the one-cycle history they compare against always comes from a cycle after reset. The stimulus meets this by changing inputs only at falling edges, and by driving reset low across several edges before releasing it.

Random mode switches are allowed, so the backplane check restarts its period counter whenever LCD mode is left.

// File: rtl/bcd_seg_pkg.sv
package bcd_seg_pkg;
  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned SEG_N   = 7;
  typedef logic [DIGIT_W-1:0] digit_t;
  typedef logic [SEG_N-1:0]   seg_t;
  localparam seg_t SEG_OFF = '0;
endpackage

// File: rtl/bcd_digit_store.sv
module bcd_digit_store
  import bcd_seg_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   track_i,
  input  digit_t digit_i,
  output digit_t next_o,
  output digit_t store_o
);
  digit_t store_q;

  assign next_o  = track_i ? digit_i : store_q;
  assign store_o = store_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) store_q <= '0;
    else         store_q <= next_o;

  AST_HOLD_DIGIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(track_i)) |-> $stable(store_q)); // R3
endmodule

// File: rtl/bcd_seg_decode.sv
module bcd_seg_decode
  import bcd_seg_pkg::*;
(
  input  digit_t code_i,
  input  logic   blank_i,
  output seg_t   seg_o
);
  seg_t raw;

  always_comb begin
    unique case (code_i)
      4'd0:    raw = 7'h3F;
      4'd1:    raw = 7'h06;
      4'd2:    raw = 7'h5B;
      4'd3:    raw = 7'h4F;
      4'd4:    raw = 7'h66;
      4'd5:    raw = 7'h6D;
      4'd6:    raw = 7'h7D;
      4'd7:    raw = 7'h07;
      4'd8:    raw = 7'h7F;
      4'd9:    raw = 7'h6F;
      default: raw = SEG_OFF;
    endcase
  end

  assign seg_o = blank_i ? SEG_OFF : raw;
endmodule

// File: rtl/bcd_phase_gen.sv
module bcd_phase_gen #(
  parameter int unsigned DIV_CLKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  output logic bp_next_o,
  output logic bp_o
);
  localparam int unsigned CNT_W = (DIV_CLKS > 1) ? $clog2(DIV_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_CLKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             bp_q;
  logic             wrap;

  assign wrap = (cnt_q == CNT_LAST);

  always_comb begin
    if (!enable_i) begin
      cnt_d     = '0;
      bp_next_o = 1'b0;
    end else begin
      cnt_d     = wrap ? '0 : cnt_q + 1'b1;
      bp_next_o = wrap ? ~bp_q : bp_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q <= '0;
      bp_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      bp_q  <= bp_next_o;
    end

  assign bp_o = bp_q;

  // Period checker: cycles since the last backplane edge in LCD mode.
  logic [31:0] chk_run_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                      chk_run_q <= '0;
    else if (!enable_i || bp_next_o != bp_q) chk_run_q <= '0;
    else                              chk_run_q <= chk_run_q + 1;

  AST_BP_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_run_q < DIV_CLKS); // R9
  AST_BP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(enable_i)) |-> !bp_q); // R10
endmodule

// File: rtl/bcd_seg_latch.sv
module bcd_seg_latch
  import bcd_seg_pkg::*;
#(
  parameter int unsigned DIV_CLKS = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] digit_i,
  input  logic       track_i,
  input  logic       blank_i,
  input  logic       invert_i,
  input  logic       lcd_mode_i,
  output logic [6:0] seg_o,
  output logic       backplane_o
);
  digit_t code_next, code_store;
  seg_t   seg_plain;
  seg_t   seg_q;
  logic   bp_next;
  logic   phase;

  bcd_digit_store u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .track_i (track_i),
    .digit_i (digit_i),
    .next_o  (code_next),
    .store_o (code_store)
  );

  bcd_seg_decode u_dec (
    .code_i  (code_next),
    .blank_i (blank_i),
    .seg_o   (seg_plain)
  );

  bcd_phase_gen #(.DIV_CLKS(DIV_CLKS)) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (lcd_mode_i),
    .bp_next_o (bp_next),
    .bp_o      (backplane_o)
  );

  // Use the backplane's next value so segments and backplane flip together.
  assign phase = lcd_mode_i ? bp_next : invert_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) seg_q <= SEG_OFF;
    else         seg_q <= seg_plain ^ {SEG_N{phase}};

  assign seg_o = seg_q;

  AST_BLANK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(blank_i) && !$past(lcd_mode_i) && !$past(invert_i))
      |-> (seg_o == SEG_OFF)); // R6
  AST_BLANK_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(blank_i) && !$past(lcd_mode_i) && $past(invert_i))
      |-> (seg_o == '1)); // R8
  AST_LCD_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(blank_i) && $past(lcd_mode_i))
      |-> (seg_o == {SEG_N{backplane_o}})); // R9
  AST_STORE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(track_i)) |-> (code_store == $past(digit_i))); // R2
endmodule

// File: tb/bcd_seg_latch_tb_top.sv
`timescale 1ns/1ps
module bcd_seg_latch_tb_top;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] digit = '0;
  logic       track = 1'b0, blank = 1'b0, inv = 1'b0, lcd = 1'b0;
  logic [6:0] seg;
  logic       bp;

  int n_chk = 0, n_err = 0;
  logic [3:0] m_store = '0;
  int         m_cnt = 0;
  logic       m_bp = 1'b0;
  logic       done = 1'b0;

  always #2.5 clk = ~clk;

  bcd_seg_latch #(.DIV_CLKS(DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .digit_i(digit), .track_i(track),
    .blank_i(blank), .invert_i(inv), .lcd_mode_i(lcd),
    .seg_o(seg), .backplane_o(bp)
  );

  function automatic logic [6:0] pat(input logic [3:0] c);
    case (c)
      4'd0: return 7'h3F; 4'd1: return 7'h06; 4'd2: return 7'h5B;
      4'd3: return 7'h4F; 4'd4: return 7'h66; 4'd5: return 7'h6D;
      4'd6: return 7'h7D; 4'd7: return 7'h07; 4'd8: return 7'h7F;
      4'd9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: inputs already set; update model at the edge, compare at the next falling edge.
  task automatic step(input string tag);
    logic [6:0] e;
    logic ph;
    @(posedge clk);
    if (track) m_store = digit;
    if (!lcd) begin m_cnt = 0; m_bp = 1'b0; end
    else if (m_cnt == DIV - 1) begin m_cnt = 0; m_bp = ~m_bp; end
    else m_cnt++;
    ph = lcd ? m_bp : inv;
    e  = (blank ? 7'h00 : pat(m_store)) ^ {7{ph}};
    @(negedge clk);
    check(tag, {1'b0, seg}, {1'b0, e});
    check(tag, {7'b0, bp}, {7'b0, m_bp});
  endtask

  function automatic string auto_tag();
    if (blank) return inv ? "R8" : "R6";
    if (lcd) return "R9";
    if (!track) return "R3";
    if (digit > 9) return "R5";
    if (inv) return "R8";
    return "R4";
  endfunction

  task automatic drive(input logic [3:0] d, input logic t, input logic b,
                       input logic i, input logic l);
    digit = d; track = t; blank = b; inv = i; lcd = l;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check("R1", {1'b0, seg}, 8'h00);
    check("R1", {7'b0, bp}, 8'h00);
    rst_n = 1'b1;
    drive(4'd9, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R1");

    // All 16 codes, both LED phases.
    for (int p = 0; p < 2; p++)
      for (int c = 0; c < 16; c++) begin
        drive(4'(c), 1'b1, 1'b0, p[0], 1'b0);
        step(c > 9 ? "R5" : (p == 1 ? "R8" : "R4"));
      end

    // Hold: track low, digit wanders.
    drive(4'd6, 1'b1, 1'b0, 1'b0, 1'b0); step("R2");
    for (int k = 0; k < 4; k++) begin
      drive(4'(k * 3 + 1), 1'b0, 1'b0, 1'b0, 1'b0); step("R3");
    end

    // Capture while blanked, then release.
    drive(4'd2, 1'b1, 1'b1, 1'b0, 1'b0); step("R6");
    drive(4'd7, 1'b1, 1'b1, 1'b0, 1'b0); step("R7");
    drive(4'd0, 1'b0, 1'b0, 1'b0, 1'b0); step("R7");
    check("R7", {1'b0, seg}, 8'h07);

    // Latency: no change before the edge.
    drive(4'd8, 1'b1, 1'b0, 1'b0, 1'b0);
    #1 check("R11", {1'b0, seg}, 8'h07);
    step("R11");
    check("R11", {1'b0, seg}, 8'h7F);

    // LED mode ignores the divider; invert_i selects phase.
    drive(4'd3, 1'b1, 1'b0, 1'b1, 1'b0);
    for (int k = 0; k < DIV + 2; k++) step("R10");

    // LCD run.
    for (int k = 0; k < 4 * DIV + 3; k++) begin
      drive(4'($urandom_range(0, 15)), 1'b1, (k % 5) == 0, 1'b0, 1'b1);
      step("R9");
    end

    // Random mix.
    for (int k = 0; k < 400; k++) begin
      drive(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
            $urandom_range(0, 7) == 0, 1'($urandom_range(0, 1)),
            $urandom_range(0, 3) == 0);
      step(auto_tag());
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin #(5.0 * 200000); n_chk++; n_err++; $display("FAIL watchdog expired"); end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule